// File: doc/BRIEF.md
# I2C Eight-Bit I/O Expander

This block is an I2C-bus slave that gives a host controller an eight-bit general-purpose port. The host writes a command byte to pick one of four internal registers. Those registers hold the captured pin levels, the values to drive, a per-bit read inversion mask and a per-bit direction mask. Data bytes that follow are written to the selected register. For a read, the host issues a repeated start and the block sends the selected register back, once per byte, until the host stops acknowledging.

The serial clock and data lines come in from the pads as raw levels. They are oversampled by the system clock and pass through a short agreement filter before the bus state machine sees them. The data line is driven only low, through `sdaOe`. Three strap inputs set the low bits of the seven-bit slave address, so eight of these blocks can share one bus. Each port pin has its own output value and output enable. Pin 0 is an open-drain pin that can never drive high.

Top module: `ioexp_top`

## Requirements
- R1: The slave address is {4'b0011, strapAddr}. An address byte whose upper seven bits differ from it gets no acknowledge, and the rest of that transaction changes no register.
- R2: A write transaction is an address byte with bit 0 = 0, a command byte and then data bytes. The block acknowledges every byte. Each data byte is stored in the register selected by command bits [1:0] (0 input, 1 output, 2 inversion, 3 direction), so the last of several data bytes is the one that remains.
- R3: After a command byte, a repeated start and an address byte with bit 0 = 1, the block returns the selected register MSB first. It repeats the same register for every byte the host acknowledges, and releases the data line after a byte the host does not acknowledge.
- R4: A direction bit of 1 makes its pin an input (`pinOe` low). A direction bit of 0 enables the driver on pins 7..1.
- R5: `pinOut[7:1]` always shows the stored output register bits, whatever the direction. Only pins whose driver is enabled present the value on the bus.
- R6: Pin 0 is open-drain. `pinOut[0]` is always 0, and `pinOe[0]` is high only when direction bit 0 is 0 and output bit 0 is 0.
- R7: The input register holds the pin level XOR the inversion bit, per bit.
- R8: The input register captures the pins on the rising clock edge of the address-byte acknowledge. It stays unchanged for every byte of the read that follows, even when the pins change.
- R9: A data byte written to register 0 is acknowledged. It changes no register and no pin output.
- R10: While `rstN` is low, and after power-up, the direction register is 8'hFF and the output and inversion registers are 8'h00, so no pin is driven.
- R11: A pulse on either bus line that is shorter than `FiltStages` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rstN | input | 1 | Active-low asynchronous reset to the default state |
| sclIn | input | 1 | Raw serial clock level from the pad |
| sdaIn | input | 1 | Raw serial data level from the pad |
| sdaOe | output | 1 | When high, the pad pulls the data line low |
| strapAddr | input | 3 | Low three bits of the slave address |
| pinIn | input | 8 | Levels seen on the port pins |
| pinOut | output | 8 | Values presented to the port pin drivers |
| pinOe | output | 8 | Per-pin driver enable, high = drive |

## Verification
The bench builds the block with its default parameters: a three-sample filter window, the fixed upper address nibble and open-drain on pin 0 only. The strap inputs are tied to 3'b101. With a three-sample window, a two-clock pulse on either line sits just below the filter threshold. This lets the bench inject an extra clock edge and a false start inside one data byte and show that both are ignored. Keeping pin 0 as the only open-drain pin means one set of direction/output patterns covers the open-drain pin and the push-pull pins side by side.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;

  localparam int PortW = 8;

  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_DIR = 2'd3
  } regSel_e;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic             capture;
    logic             wrEn;
    regSel_e          sel;
    logic [PortW-1:0] wrData;
  } ctlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_SKIP
  } busSt_e;

endpackage

// File: rtl/ioexp_glitch.sv
module ioexp_glitch #(
  parameter int Stages = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  logic [1:0]        syncQ;
  logic [Stages-1:0] hist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      hist     <= '1;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      hist  <= {hist[Stages-2:0], syncQ[1]};
      if (&hist)       cleanOut <= 1'b1;
      else if (~|hist) cleanOut <= 1'b0;
    end
  end

  // R11
  filt_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cleanOut) |-> ($past(syncQ[1], 2) == cleanOut) && ($past(syncQ[1], 3) == cleanOut));

endmodule

// File: rtl/ioexp_ctrl.sv
module ioexp_ctrl
  import ioexp_pkg::*;
#(
  parameter logic [3:0] AddrHi = 4'b0011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclF,
  input  logic             sdaF,
  input  logic [2:0]       strapAddr,
  input  logic [PortW-1:0] rdData,
  output logic             sdaOe,
  output ctlStrb_t         strb
);

  localparam logic [3:0] BitLast = 4'(PortW);
  localparam logic [3:0] AckBit  = 4'(PortW + 1);

  busSt_e           state;
  logic [3:0]       bitCnt;
  logic [PortW-1:0] shiftReg;
  logic [PortW-1:0] txShift;
  logic             sclQ, sdaQ;
  logic             sdaDrive, isRead, masterAck;
  logic             capPulse, wrPulse;
  logic [PortW-1:0] wrByte;
  regSel_e          regSel;

  logic sclRise, sclFall, startDet, stopDet, addrHit;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
  assign addrHit  = (shiftReg[7:1] == {AddrHi, strapAddr});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txShift   <= '0;
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      sdaDrive  <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      capPulse  <= 1'b0;
      wrPulse   <= 1'b0;
      wrByte    <= '0;
      regSel    <= SEL_IN;
    end else begin
      sclQ     <= sclF;
      sdaQ     <= sdaF;
      capPulse <= 1'b0;
      wrPulse  <= 1'b0;
      if (startDet) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        sdaDrive <= 1'b0;
      end else if (stopDet) begin
        state    <= ST_IDLE;
        sdaDrive <= 1'b0;
      end else if (sclRise) begin
        case (state)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (bitCnt < BitLast) begin
              shiftReg <= {shiftReg[PortW-2:0], sdaF};
              bitCnt   <= bitCnt + 4'd1;
            end else if (bitCnt == AckBit && state == ST_ADDR) begin
              capPulse <= 1'b1;
            end
          end
          ST_RD: begin
            if (bitCnt < BitLast)      bitCnt    <= bitCnt + 4'd1;
            else if (bitCnt == AckBit) masterAck <= ~sdaF;
          end
          default: ;
        endcase
      end else if (sclFall) begin
        case (state)
          ST_ADDR: begin
            if (bitCnt == BitLast) begin
              if (addrHit) begin
                sdaDrive <= 1'b1;
                isRead   <= shiftReg[0];
                bitCnt   <= AckBit;
              end else begin
                state <= ST_SKIP;
              end
            end else if (bitCnt == AckBit) begin
              bitCnt <= '0;
              if (isRead) begin
                state    <= ST_RD;
                txShift  <= rdData;
                sdaDrive <= ~rdData[PortW-1];
              end else begin
                state    <= ST_CMD;
                sdaDrive <= 1'b0;
              end
            end
          end
          ST_CMD: begin
            if (bitCnt == BitLast) begin
              regSel   <= regSel_e'(shiftReg[1:0]);
              sdaDrive <= 1'b1;
              bitCnt   <= AckBit;
            end else if (bitCnt == AckBit) begin
              sdaDrive <= 1'b0;
              bitCnt   <= '0;
              state    <= ST_WR;
            end
          end
          ST_WR: begin
            if (bitCnt == BitLast) begin
              wrPulse  <= 1'b1;
              wrByte   <= shiftReg;
              sdaDrive <= 1'b1;
              bitCnt   <= AckBit;
            end else if (bitCnt == AckBit) begin
              sdaDrive <= 1'b0;
              bitCnt   <= '0;
            end
          end
          ST_RD: begin
            if (bitCnt == BitLast) begin
              sdaDrive <= 1'b0;
              bitCnt   <= AckBit;
            end else if (bitCnt == AckBit) begin
              if (masterAck) begin
                txShift  <= rdData;
                sdaDrive <= ~rdData[PortW-1];
                bitCnt   <= '0;
              end else begin
                state    <= ST_SKIP;
                sdaDrive <= 1'b0;
              end
            end else if (bitCnt != 4'd0) begin
              txShift  <= {txShift[PortW-2:0], 1'b0};
              sdaDrive <= ~txShift[PortW-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe = sdaDrive;

  always_comb begin
    strb.capture = capPulse;
    strb.wrEn    = wrPulse;
    strb.sel     = regSel;
    strb.wrData  = wrByte;
  end

  // R3
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclQ);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_SKIP) |-> !sdaOe);

endmodule

// File: rtl/ioexp_regs.sv
module ioexp_regs
  import ioexp_pkg::*;
#(
  parameter logic [PortW-1:0] OdMask = 8'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [PortW-1:0] pinIn,
  output logic [PortW-1:0] rdData,
  output logic [PortW-1:0] pinOut,
  output logic [PortW-1:0] pinOe
);

  logic [PortW-1:0] inReg, outReg, polReg, cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg  <= '0;
      outReg <= '0;
      polReg <= '0;
      cfgReg <= '1;
    end else begin
      if (strb.capture) inReg <= pinIn ^ polReg;
      if (strb.wrEn) begin
        case (strb.sel)
          SEL_OUT: outReg <= strb.wrData;
          SEL_POL: polReg <= strb.wrData;
          SEL_DIR: cfgReg <= strb.wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_OUT: rdData = outReg;
      SEL_POL: rdData = polReg;
      SEL_DIR: rdData = cfgReg;
      default: rdData = inReg;
    endcase
  end

  for (genvar i = 0; i < PortW; i++) begin : gPin
    if (OdMask[i]) begin : gOd
      assign pinOut[i] = 1'b0;
      assign pinOe[i]  = ~cfgReg[i] & ~outReg[i];
      // R6
      od_no_high_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrEn && strb.sel == SEL_OUT && strb.wrData[i] |=> !pinOe[i]);
    end else begin : gPp
      assign pinOut[i] = outReg[i];
      assign pinOe[i]  = ~cfgReg[i];
    end
  end

  // R4
  dir_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && strb.sel == SEL_DIR |=> ((pinOe & ~OdMask) == (~$past(strb.wrData) & ~OdMask)));

  // R8
  in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(inReg));

  // R9
  in_write_void_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && strb.sel == SEL_IN |=> $stable(outReg) && $stable(polReg) && $stable(cfgReg));

endmodule

// File: rtl/ioexp_top.sv
module ioexp_top
  import ioexp_pkg::*;
#(
  parameter int               FiltStages = 3,
  parameter logic [3:0]       AddrHi     = 4'b0011,
  parameter logic [PortW-1:0] OdMask     = 8'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [2:0]       strapAddr,
  input  logic [PortW-1:0] pinIn,
  output logic [PortW-1:0] pinOut,
  output logic [PortW-1:0] pinOe
);

  logic [1:0]       rawLines, cleanLines;
  ctlStrb_t         strb;
  logic [PortW-1:0] rdData;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : gFilt
    ioexp_glitch #(.Stages(FiltStages)) uFilt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawLines[g]),
      .cleanOut (cleanLines[g])
    );
  end

  ioexp_ctrl #(.AddrHi(AddrHi)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclF      (cleanLines[0]),
    .sdaF      (cleanLines[1]),
    .strapAddr (strapAddr),
    .rdData    (rdData),
    .sdaOe     (sdaOe),
    .strb      (strb)
  );

  ioexp_regs #(.OdMask(OdMask)) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

endmodule

// File: tb/sim_ioexp_top.sv
module sim_ioexp_top;

  localparam int ClkPeriod = 10;
  localparam int Q = 8;
  localparam int H = 16;
  localparam logic [7:0] WrAddr = 8'h3A;  // {4'b0011, 3'b101, 0}
  localparam logic [7:0] RdAddr = 8'h3B;
  localparam logic [7:0] BadAddr = 8'h38;
  // {dir, out, inv, pins, expOe, expOut, expIn}
  localparam logic [55:0] Vecs [4] = '{
    56'h00_A5_00_3C_FE_A4_3C,
    56'hF0_5A_FF_0F_0F_5A_F0,
    56'hFF_FF_0F_81_00_FE_8E,
    56'h0E_01_A0_55_F0_00_F5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [7:0] pinIn = 8'h00;
  logic sdaOe, sdaLine;
  logic [7:0] pinOut, pinOe;
  int errs = 0;
  int checks = 0;

  assign sdaLine = mSda & ~sdaOe;

  always #(ClkPeriod / 2) clk = ~clk;

  ioexp_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapAddr(3'b101), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b0; waitClk(H);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i];
      waitClk(Q / 2);
      if (glitch && i == 4) begin
        mScl = 1'b1; waitClk(2); mScl = 1'b0;
      end
      waitClk(Q / 2);
      mScl = 1'b1;
      if (glitch && i == 6 && b[i]) begin
        waitClk(H / 2); mSda = 1'b0; waitClk(2); mSda = 1'b1; waitClk(H / 2 - 2);
      end else begin
        waitClk(H);
      end
      mScl = 1'b0;
      waitClk(Q);
    end
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(H / 2);
    ack = (sdaLine == 1'b0);
    waitClk(H / 2);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q);
      mScl = 1'b1; waitClk(H / 2);
      b[i] = sdaLine;
      waitClk(H / 2);
      mScl = 1'b0;
    end
    waitClk(Q / 2); mSda = ~ackIt; waitClk(Q / 2);
    mScl = 1'b1; waitClk(H);
    mScl = 1'b0; waitClk(Q / 2);
    mSda = 1'b1; waitClk(Q / 2);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data, input bit glitch);
    bit a0, a1, a2;
    busStart();
    sendByte(WrAddr, 1'b0, a0);
    sendByte({6'd0, sel}, 1'b0, a1);
    sendByte(data, glitch, a2);
    busStop();
    chk("R2 write acks", {5'd0, a0, a1, a2}, 8'h07);
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] b);
    bit a0, a1, a2;
    busStart();
    sendByte(WrAddr, 1'b0, a0);
    sendByte({6'd0, sel}, 1'b0, a1);
    busStart();
    sendByte(RdAddr, 1'b0, a2);
    recvByte(1'b0, b);
    busStop();
    chk("R3 read acks", {5'd0, a0, a1, a2}, 8'h07);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd, rd2;
    logic [55:0] v;
    bit a0, a1, a2, a3;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R10 reset state
    chk("R10 pinOe after reset", pinOe, 8'h00);
    readReg(2'd3, rd); chk("R10 dir reset", rd, 8'hFF);
    readReg(2'd1, rd); chk("R10 out reset", rd, 8'h00);
    readReg(2'd2, rd); chk("R10 inv reset", rd, 8'h00);

    // vector table: direction, output, inversion, pin levels
    for (int i = 0; i < 4; i++) begin
      v = Vecs[i];
      writeReg(2'd3, v[55:48], 1'b0);
      writeReg(2'd1, v[47:40], 1'b0);
      writeReg(2'd2, v[39:32], 1'b0);
      pinIn = v[31:24];
      readReg(2'd0, rd);
      chk("R7 input read", rd, v[7:0]);
      chk("R4 pinOe", pinOe, v[23:16]);
      chk("R5 pinOut", pinOut, v[15:8]);
      chk("R6 pin0 enable", {7'd0, pinOe[0]}, {7'd0, v[16]});
      chk("R6 pin0 value", {7'd0, pinOut[0]}, 8'h00);
      readReg(2'd3, rd);
      chk("R2 dir readback", rd, v[55:48]);
    end

    // R9 write to input register is ignored (dir=0E out=01 inv=A0 now)
    writeReg(2'd0, 8'hFF, 1'b0);
    chk("R9 pinOut unchanged", pinOut, 8'h00);
    chk("R9 pinOe unchanged", pinOe, 8'hF0);
    readReg(2'd1, rd); chk("R9 out unchanged", rd, 8'h01);

    // R1 wrong address
    busStart();
    sendByte(BadAddr, 1'b0, a0);
    sendByte(8'h03, 1'b0, a1);
    sendByte(8'hFF, 1'b0, a2);
    busStop();
    chk("R1 no ack", {7'd0, a0}, 8'h00);
    chk("R1 pinOe unchanged", pinOe, 8'hF0);
    readReg(2'd3, rd); chk("R1 dir unchanged", rd, 8'h0E);

    // R2 two data bytes in one write
    busStart();
    sendByte(WrAddr, 1'b0, a0);
    sendByte(8'h01, 1'b0, a1);
    sendByte(8'h12, 1'b0, a2);
    sendByte(8'h34, 1'b0, a3);
    busStop();
    chk("R2 multi acks", {4'd0, a0, a1, a2, a3}, 8'h0F);
    chk("R2 last byte kept", pinOut, 8'h34);

    // R8 capture at address acknowledge, R3 repeated bytes
    pinIn = 8'h3C;
    busStart();
    sendByte(WrAddr, 1'b0, a0);
    sendByte(8'h00, 1'b0, a1);
    busStart();
    sendByte(RdAddr, 1'b0, a2);
    pinIn = 8'hC3;
    recvByte(1'b1, rd);
    recvByte(1'b0, rd2);
    busStop();
    chk("R8 first byte held", rd, 8'h9C);
    chk("R3 second byte same", rd2, 8'h9C);
    chk("R8 second sdaOe released", {7'd0, sdaOe}, 8'h00);
    readReg(2'd0, rd); chk("R7 new capture", rd, 8'h63);

    // R11 short pulses on both lines inside a data byte
    writeReg(2'd1, 8'h56, 1'b1);
    chk("R11 glitches ignored", pinOut, 8'h56);

    // R10 reset mid-run
    rstN = 1'b0;
    waitClk(3);
    chk("R10 pinOe in reset", pinOe, 8'h00);
    rstN = 1'b1;
    waitClk(5);
    readReg(2'd3, rd); chk("R10 dir after reset", rd, 8'hFF);
    readReg(2'd1, rd); chk("R10 out after reset", rd, 8'h00);

    summary();
    $finish;
  end

endmodule